// File: doc/BRIEF.md
# Byte-Lane Parity Guard with Sticky Error Capture

This block protects a 32-bit memory data path with one odd-parity bit for each of its four byte lanes. On a write it computes the parity bit of every enabled lane and hands it, with a per-lane write strobe, to a sideband parity store. On a read it recomputes the parity of each returned lane and compares it with the stored bit. Whether it generates or checks parity at all, and whether it deliberately stores wrong parity, is set by software.

When a checked read mismatches, the block records which lanes failed and the address of the read. That record is sticky: later faults leave it untouched until software clears it. A captured fault can drive a top-priority interrupt request line. Software reaches the block through a small window: a control/status byte at offset 0 and a 32-bit error address word at offset 4. The offsets between them are pad bytes that read as zero.

Control/status byte layout: bit 7 pending (read-only), bit 6 interrupt enable, bit 5 parity-invert test, bit 4 check enable, bits 3..0 lane fault flags (read-only; bit 3 is lane 31:24, bit 2 is lane 23:16, bit 1 is lane 15:8, bit 0 is lane 7:0).

Top module: `par_mem_guard`

## Requirements
- R1: On a write cycle, `par_we[i]` equals `wr_be[i]` and `par_wbits[i]` is the odd-parity bit of lane i (bits 8i+7..8i). It is 1 when the lane holds an even number of ones. With no write cycle, `par_we` is 0.
- R2: While control bit 5 (test) is set, every stored parity bit is the inverse of the correct odd-parity bit, so a later checked read of that word flags every written lane.
- R3: A read with check enable set whose stored parity mismatches in one or more lanes sets bit 7 (pending) and the flag of each failing lane in the same event. It also loads the read address into the word at offset 4. All of this is visible from the cycle after the read. A clean read changes nothing.
- R4: While control bit 4 (check enable) is clear, parity faults on reads are neither detected nor recorded.
- R5: While an error is pending, further faulting reads change neither the lane flags nor the captured address.
- R6: A write to offset 0 loads bits 6..4 from the write data. If write-data bit 7 is 1, it also clears the pending bit and bits 3..0. Read-only bits never take the write data.
- R7: `irq` is high exactly while an error is pending and bit 6 is set. Clearing bit 6 (with write bit 7 at 0) masks `irq` but keeps the captured error.
- R8: Writes to offset 4 are ignored. Bits 31..8 of the offset-0 read and every pad offset read as zero.
- R9: After reset, the control/status byte, the error address and `irq` are all zero.
- R10: If a faulting checked read coincides with a clearing write, the new fault is captured (pending set, new flags and address) rather than lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_valid | input | 1 | Memory write cycle |
| wr_be | input | 4 | Byte enables of the write |
| wr_data | input | 32 | Write data |
| par_we | output | 4 | Per-lane write strobe to the parity store |
| par_wbits | output | 4 | Parity bits to store |
| rd_valid | input | 1 | Read data returned this cycle |
| rd_addr | input | 32 | Address of the read |
| rd_data | input | 32 | Returned read data |
| rd_par | input | 4 | Returned stored parity bits |
| reg_sel | input | 1 | Register window access |
| reg_we | input | 1 | Access is a write |
| reg_off | input | 3 | Byte offset within the window |
| reg_wdata | input | 4 | Write data for control/status bits 7..4 |
| reg_rdata | output | 32 | Read data for the addressed offset |
| irq | output | 1 | Top-priority interrupt request |

## Verification
The bound checker watches every cycle for several conditions. Parity strobes must stay inside the byte enables and be silent without a write. Pending must agree with a non-empty flag set. A new capture must only follow a checked read. While pending, the captured flags and address must not move. A clearing write must empty the record, address-word writes must leave the address alone, and `irq` must never rise without a fault. The exact parity values, the lane-to-flag mapping, the inverted test parity, masking without loss, and the capture that wins over a same-cycle clear depend on data stored in the modelled memory. Only the directed scenarios of the bench can show these.

// File: rtl/pmg_pkg.sv
package pmg_pkg;

    localparam int unsigned PMG_LANES  = 4;
    localparam int unsigned PMG_LANE_W = 8;
    localparam int unsigned PMG_DATA_W = PMG_LANES * PMG_LANE_W;
    localparam int unsigned PMG_ADDR_W = 32;
    localparam int unsigned PMG_OFF_W  = 3;

    localparam logic [PMG_OFF_W-1:0] PMG_OFF_CSR  = 3'd0;
    localparam logic [PMG_OFF_W-1:0] PMG_OFF_ADDR = 3'd4;

    // control/status byte, bit 7 down to bit 0
    typedef struct packed {
        logic                 pend;
        logic                 ien;
        logic                 test;
        logic                 chk;
        logic [PMG_LANES-1:0] flags;
    } pmg_csr_t;

    // writable upper nibble as it arrives from the window
    typedef struct packed {
        logic clr;
        logic ien;
        logic test;
        logic chk;
    } pmg_ctrl_wr_t;

    function automatic logic pmg_odd_par(input logic [PMG_LANE_W-1:0] lane);
        return ~(^lane);
    endfunction

endpackage

// File: rtl/pmg_wr_par.sv
module pmg_wr_par
    import pmg_pkg::*;
#(
    parameter int unsigned LANES  = PMG_LANES,
    parameter int unsigned LANE_W = PMG_LANE_W,
    localparam int unsigned DW    = LANES * LANE_W
) (
    input  logic             wr_valid,
    input  logic [LANES-1:0] wr_be,
    input  logic [DW-1:0]    wr_data,
    input  logic             invert,
    output logic [LANES-1:0] par_we,
    output logic [LANES-1:0] par_wbits
);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign par_we[g]    = wr_valid & wr_be[g];
        assign par_wbits[g] = pmg_odd_par(wr_data[g*LANE_W +: LANE_W]) ^ invert;
    end

endmodule

// File: rtl/pmg_rd_chk.sv
module pmg_rd_chk
    import pmg_pkg::*;
#(
    parameter int unsigned LANES  = PMG_LANES,
    parameter int unsigned LANE_W = PMG_LANE_W,
    localparam int unsigned DW    = LANES * LANE_W
) (
    input  logic             rd_valid,
    input  logic             chk_en,
    input  logic [DW-1:0]    rd_data,
    input  logic [LANES-1:0] rd_par,
    output logic [LANES-1:0] lane_fail,
    output logic             hit
);

    logic [LANES-1:0] mism;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign mism[g] = pmg_odd_par(rd_data[g*LANE_W +: LANE_W]) != rd_par[g];
    end

    assign lane_fail = (rd_valid && chk_en) ? mism : '0;
    assign hit       = |lane_fail;

endmodule

// File: rtl/pmg_capture.sv
module pmg_capture
    import pmg_pkg::*;
#(
    parameter int unsigned LANES = PMG_LANES,
    parameter int unsigned AW    = PMG_ADDR_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             csr_wr,
    input  pmg_ctrl_wr_t     ctrl_wr,
    input  logic             hit,
    input  logic [LANES-1:0] lane_fail,
    input  logic [AW-1:0]    rd_addr,
    output pmg_csr_t         csr_q,
    output logic [AW-1:0]    err_addr_q
);

    logic clr;
    logic cap;

    assign clr = csr_wr & ctrl_wr.clr;
    // a fault is taken when the record is empty or being emptied now
    assign cap = hit & (~csr_q.pend | clr);

    always_ff @(posedge clk) begin
        if (rst) begin
            csr_q      <= '0;
            err_addr_q <= '0;
        end else begin
            if (csr_wr) begin
                csr_q.ien  <= ctrl_wr.ien;
                csr_q.test <= ctrl_wr.test;
                csr_q.chk  <= ctrl_wr.chk;
            end
            if (cap) begin
                csr_q.pend  <= 1'b1;
                csr_q.flags <= lane_fail;
                err_addr_q  <= rd_addr;
            end else if (clr) begin
                csr_q.pend  <= 1'b0;
                csr_q.flags <= '0;
            end
        end
    end

endmodule

// File: rtl/pmg_regwin.sv
module pmg_regwin
    import pmg_pkg::*;
#(
    parameter int unsigned AW    = PMG_ADDR_W,
    parameter int unsigned OFF_W = PMG_OFF_W,
    parameter int unsigned RW    = 32
) (
    input  logic             reg_sel,
    input  logic             reg_we,
    input  logic [OFF_W-1:0] reg_off,
    input  logic [3:0]       reg_wdata,
    input  pmg_csr_t         csr_q,
    input  logic [AW-1:0]    err_addr_q,
    output logic             csr_wr,
    output pmg_ctrl_wr_t     ctrl_wr,
    output logic [RW-1:0]    reg_rdata
);

    localparam int unsigned CSR_W = $bits(pmg_csr_t);

    assign csr_wr  = reg_sel & reg_we & (reg_off == PMG_OFF_CSR);
    assign ctrl_wr = pmg_ctrl_wr_t'(reg_wdata);

    always_comb begin
        reg_rdata = '0;
        case (reg_off)
            PMG_OFF_CSR:  reg_rdata[CSR_W-1:0] = csr_q;
            PMG_OFF_ADDR: reg_rdata = RW'(err_addr_q);
            default:      reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/par_mem_guard.sv
module par_mem_guard
    import pmg_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr_valid,
    input  logic [PMG_LANES-1:0]  wr_be,
    input  logic [PMG_DATA_W-1:0] wr_data,
    output logic [PMG_LANES-1:0]  par_we,
    output logic [PMG_LANES-1:0]  par_wbits,
    input  logic                  rd_valid,
    input  logic [PMG_ADDR_W-1:0] rd_addr,
    input  logic [PMG_DATA_W-1:0] rd_data,
    input  logic [PMG_LANES-1:0]  rd_par,
    input  logic                  reg_sel,
    input  logic                  reg_we,
    input  logic [PMG_OFF_W-1:0]  reg_off,
    input  logic [3:0]            reg_wdata,
    output logic [31:0]           reg_rdata,
    output logic                  irq
);

    pmg_csr_t               csr_q;
    logic [PMG_ADDR_W-1:0]  err_addr_q;
    logic [PMG_LANES-1:0]   lane_fail;
    logic                   hit;
    logic                   csr_wr;
    pmg_ctrl_wr_t           ctrl_wr;

    pmg_wr_par u_wr_par (
        .wr_valid  (wr_valid),
        .wr_be     (wr_be),
        .wr_data   (wr_data),
        .invert    (csr_q.test),
        .par_we    (par_we),
        .par_wbits (par_wbits)
    );

    pmg_rd_chk u_rd_chk (
        .rd_valid  (rd_valid),
        .chk_en    (csr_q.chk),
        .rd_data   (rd_data),
        .rd_par    (rd_par),
        .lane_fail (lane_fail),
        .hit       (hit)
    );

    pmg_regwin u_regwin (
        .reg_sel    (reg_sel),
        .reg_we     (reg_we),
        .reg_off    (reg_off),
        .reg_wdata  (reg_wdata),
        .csr_q      (csr_q),
        .err_addr_q (err_addr_q),
        .csr_wr     (csr_wr),
        .ctrl_wr    (ctrl_wr),
        .reg_rdata  (reg_rdata)
    );

    pmg_capture u_capture (
        .clk        (clk),
        .rst        (rst),
        .csr_wr     (csr_wr),
        .ctrl_wr    (ctrl_wr),
        .hit        (hit),
        .lane_fail  (lane_fail),
        .rd_addr    (rd_addr),
        .csr_q      (csr_q),
        .err_addr_q (err_addr_q)
    );

    assign irq = csr_q.pend & csr_q.ien;

endmodule

// File: rtl/pmg_checker.sv
module pmg_checker (
    input logic        clk,
    input logic        rst,
    input logic        wr_valid,
    input logic [3:0]  wr_be,
    input logic [3:0]  par_we,
    input logic        rd_valid,
    input logic        reg_sel,
    input logic        reg_we,
    input logic [2:0]  reg_off,
    input logic [3:0]  reg_wdata,
    input logic [7:0]  csr,
    input logic [31:0] err_addr,
    input logic        irq
);

    logic clr_wr;
    logic addr_wr;
    assign clr_wr  = reg_sel && reg_we && (reg_off == 3'd0) && reg_wdata[3];
    assign addr_wr = reg_sel && reg_we && (reg_off == 3'd4);

    assert_strobe_in_be_R1: assert property (@(posedge clk) disable iff (rst)
        (par_we & ~wr_be) == 4'h0);

    assert_no_strobe_idle_R1: assert property (@(posedge clk) disable iff (rst)
        !wr_valid |-> par_we == 4'h0);

    assert_pend_has_lane_R3: assert property (@(posedge clk) disable iff (rst)
        csr[7] == (csr[3:0] != 4'h0));

    assert_capture_needs_check_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(csr[7]) |-> $past(rd_valid && csr[4]));

    assert_sticky_record_R5: assert property (@(posedge clk) disable iff (rst)
        (csr[7] && !clr_wr) |=> ($stable(err_addr) && $stable(csr[3:0])));

    assert_clear_empties_R6: assert property (@(posedge clk) disable iff (rst)
        (clr_wr && !rd_valid) |=> (csr[7] == 1'b0 && csr[3:0] == 4'h0));

    assert_irq_has_cause_R7: assert property (@(posedge clk) disable iff (rst)
        irq |-> (csr[3:0] != 4'h0));

    assert_addr_write_ignored_R8: assert property (@(posedge clk) disable iff (rst)
        (addr_wr && !rd_valid) |=> $stable(err_addr));

endmodule

bind par_mem_guard pmg_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .wr_valid  (wr_valid),
    .wr_be     (wr_be),
    .par_we    (par_we),
    .rd_valid  (rd_valid),
    .reg_sel   (reg_sel),
    .reg_we    (reg_we),
    .reg_off   (reg_off),
    .reg_wdata (reg_wdata),
    .csr       (csr_q),
    .err_addr  (err_addr_q),
    .irq       (irq)
);

// File: tb/par_mem_guard_tb.sv
module par_mem_guard_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_valid = 1'b0;
    logic [3:0]  wr_be = '0;
    logic [31:0] wr_data = '0;
    logic [3:0]  par_we;
    logic [3:0]  par_wbits;
    logic        rd_valid = 1'b0;
    logic [31:0] rd_addr = '0;
    logic [31:0] rd_data = '0;
    logic [3:0]  rd_par = '0;
    logic        reg_sel = 1'b0;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_off = '0;
    logic [3:0]  reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [31:0] mem  [16];
    logic [3:0]  pmem [16];

    localparam logic [31:0] BASE = 32'h0000_1000;

    always #4 clk = ~clk;

    par_mem_guard u_dut (
        .clk(clk), .rst(rst),
        .wr_valid(wr_valid), .wr_be(wr_be), .wr_data(wr_data),
        .par_we(par_we), .par_wbits(par_wbits),
        .rd_valid(rd_valid), .rd_addr(rd_addr), .rd_data(rd_data), .rd_par(rd_par),
        .reg_sel(reg_sel), .reg_we(reg_we), .reg_off(reg_off),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
    );

    function automatic logic [3:0] exp_par(input logic [31:0] d);
        logic [3:0] r;
        for (int l = 0; l < 4; l++) begin
            int cnt = 0;
            for (int b = 0; b < 8; b++) cnt += int'(d[l*8+b]);
            r[l] = (cnt % 2 == 0);
        end
        return r;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic [2:0] off, input logic [7:0] v);
        @(negedge clk);
        reg_sel = 1'b1; reg_we = 1'b1; reg_off = off; reg_wdata = v[7:4];
        @(negedge clk);
        reg_sel = 1'b0; reg_we = 1'b0;
    endtask

    task automatic reg_read(input logic [2:0] off, output logic [31:0] v);
        @(negedge clk);
        reg_off = off;
        #1 v = reg_rdata;
    endtask

    task automatic mem_write(input int idx, input logic [31:0] d, input logic [3:0] be,
                             output logic [3:0] pwe, output logic [3:0] pbits);
        @(negedge clk);
        wr_valid = 1'b1; wr_be = be; wr_data = d;
        #1 pwe = par_we; pbits = par_wbits;
        @(posedge clk);
        for (int l = 0; l < 4; l++) begin
            if (be[l]) mem[idx][l*8 +: 8] = d[l*8 +: 8];
            if (pwe[l]) pmem[idx][l] = pbits[l];
        end
        #1 wr_valid = 1'b0; wr_be = '0;
    endtask

    task automatic drive_read(input int idx);
        rd_valid = 1'b1;
        rd_addr  = BASE + 32'(idx * 4);
        rd_data  = mem[idx];
        rd_par   = pmem[idx];
    endtask

    task automatic mem_read(input int idx);
        @(negedge clk);
        drive_read(idx);
        @(posedge clk);
        #1 rd_valid = 1'b0;
    endtask

    task automatic expect_state(input string req, input logic [7:0] csr, input logic [31:0] addr,
                                input logic irq_e);
        logic [31:0] v;
        reg_read(3'd0, v);
        check({req, " csr"}, v, {24'h0, csr});
        reg_read(3'd4, v);
        check({req, " addr"}, v, addr);
        check({req, " irq"}, {31'h0, irq}, {31'h0, irq_e});
    endtask

    task automatic t_reset;
        expect_state("R9 reset", 8'h00, 32'h0, 1'b0);
    endtask

    task automatic t_write_parity;
        logic [3:0] pwe, pb;
        mem_write(0, 32'h0103_07FF, 4'hF, pwe, pb);
        check("R1 full strobes", {28'h0, pwe}, 32'hF);
        check("R1 full parity", {28'h0, pb}, {28'h0, exp_par(32'h0103_07FF)});
        mem_write(1, 32'h7766_5544, 4'hF, pwe, pb);
        mem_write(1, 32'hA5A5_0F0E, 4'b0101, pwe, pb);
        check("R1 partial strobes", {28'h0, pwe}, 32'h5);
        check("R1 partial parity lanes", {28'h0, pb & 4'b0101},
              {28'h0, exp_par(32'hA5A5_0F0E) & 4'b0101});
    endtask

    task automatic t_clean_read;
        logic [31:0] v;
        reg_write(3'd0, 8'h50);
        reg_read(3'd0, v);
        check("R6 control load", v, 32'h50);
        mem_read(0);
        expect_state("R3 clean read", 8'h50, 32'h0, 1'b0);
    endtask

    task automatic t_single_lane;
        pmem[1][2] = ~pmem[1][2];
        mem_read(1);
        expect_state("R3/R7 lane2 fault", 8'hD4, BASE + 32'h4, 1'b1);
    endtask

    task automatic t_sticky;
        logic [3:0] pwe, pb;
        mem_write(2, 32'h0000_00F1, 4'hF, pwe, pb);
        pmem[2][0] = ~pmem[2][0];
        mem_read(2);
        expect_state("R5 sticky", 8'hD4, BASE + 32'h4, 1'b1);
    endtask

    task automatic t_mask;
        reg_write(3'd0, 8'h10);
        expect_state("R7 masked keeps record", 8'h94, BASE + 32'h4, 1'b0);
        reg_write(3'd0, 8'h50);
        check("R7 unmasked irq", {31'h0, irq}, 32'h1);
    endtask

    task automatic t_clear;
        reg_write(3'd0, 8'hD0);
        expect_state("R6 clear", 8'h50, BASE + 32'h4, 1'b0);
    endtask

    task automatic t_multi;
        logic [3:0] pwe, pb;
        mem_write(3, 32'h1122_3344, 4'hF, pwe, pb);
        pmem[3][3] = ~pmem[3][3];
        pmem[3][0] = ~pmem[3][0];
        mem_read(3);
        expect_state("R3 two lanes", 8'hD9, BASE + 32'hC, 1'b1);
        reg_write(3'd0, 8'hD0);
    endtask

    task automatic t_addr_ignore;
        logic [31:0] v;
        reg_write(3'd4, 8'hF0);
        reg_read(3'd4, v);
        check("R8 addr write ignored", v, BASE + 32'hC);
        reg_read(3'd1, v);
        check("R8 pad reads zero", v, 32'h0);
        reg_read(3'd0, v);
        check("R8 csr upper bits zero", v, 32'h50);
    endtask

    task automatic t_test_mode;
        logic [3:0] pwe, pb;
        reg_write(3'd0, 8'hB0);
        mem_write(5, 32'h1234_5678, 4'hF, pwe, pb);
        check("R2 inverted parity", {28'h0, pb}, {28'h0, ~exp_par(32'h1234_5678)});
        reg_write(3'd0, 8'h90);
        mem_read(5);
        expect_state("R2 all lanes fault", 8'h9F, BASE + 32'h14, 1'b0);
    endtask

    task automatic t_chk_off;
        reg_write(3'd0, 8'h80);
        mem_read(5);
        expect_state("R4 check disabled", 8'h00, BASE + 32'h14, 1'b0);
    endtask

    task automatic t_same_cycle;
        reg_write(3'd0, 8'h90);
        mem_read(3);
        expect_state("R10 setup", 8'h99, BASE + 32'hC, 1'b0);
        @(negedge clk);
        reg_sel = 1'b1; reg_we = 1'b1; reg_off = 3'd0; reg_wdata = 4'h9;
        drive_read(5);
        @(posedge clk);
        #1 rd_valid = 1'b0; reg_sel = 1'b0; reg_we = 1'b0;
        expect_state("R10 capture beats clear", 8'h9F, BASE + 32'h14, 1'b0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        t_reset();
        t_write_parity();
        t_clean_read();
        t_single_lane();
        t_sticky();
        t_mask();
        t_clear();
        t_multi();
        t_addr_ignore();
        t_test_mode();
        t_chk_off();
        t_same_cycle();
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog (all requirements): actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule